// File: doc/BRIEF.md
# Prescaled Timer and PWM Waveform Generator

This block makes a periodic digital waveform from the master clock. A power-of-two prescaler turns the clock into a slower tick. An 8-bit counter then advances by one on each tick. In timer mode the counter wraps after a programmed number of ticks. The output is either a square wave that flips at every wrap, or a pulse one tick period wide that is issued at every wrap. In PWM mode the counter wraps after a reload number of ticks, and the output is high while the counter is below a duty compare value.

The settings are presented on plain input ports. The block copies the count, reload, duty, mode and shape inputs into shadow registers. While the block is running, the shadow registers take new values only on the tick that ends a period, so a change made mid-period never cuts a period short. While `enable` is low, the counters are held cleared, the output is held low and the shadow registers follow the inputs.

Top module: `pwm_timer_gen`

## Requirements
- R1: With `presc_sel` = N (0..15), the prescaler issues one tick every 2^N clock cycles while enabled. A setting of 0 ticks on every cycle.
- R2: Timer mode (`pwm_mode`=0) with `out_shape`=0 gives a square wave. With L = `count_val` (0 stands for 256) and P = 2^N, the output is high for L·P cycles out of a 2·L·P cycle period.
- R3: Timer mode with `out_shape`=1 gives a pulse every L·P cycles that is high for exactly P cycles.
- R4: PWM mode (`pwm_mode`=1) has a period of R·P cycles, where R = `reload_val` (0 stands for 256). The counter runs 0..R-1, the output is high while the counter is below D = `duty_val`, and so the high time is D·P cycles.
- R5: In PWM mode, D = 0 keeps the output constantly low.
- R6: In PWM mode, D >= R keeps the output constantly high.
- R7: A change of count, reload, duty, mode or shape while running takes effect only from the next period. The period in progress finishes with the old values.
- R8: While `enable` is low the output is low from the next clock edge. While enabled, the output changes only on a clock edge that carries a tick.
- R9: During and right after reset the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; low clears counters and output |
| presc_sel | input | 4 | Prescaler exponent N, tick every 2^N cycles |
| pwm_mode | input | 1 | 1 selects PWM, 0 selects timer |
| out_shape | input | 1 | Timer shape: 0 square, 1 pulse |
| count_val | input | 8 | Timer wrap count (0 means 256) |
| reload_val | input | 8 | PWM period in ticks (0 means 256) |
| duty_val | input | 8 | PWM compare value |
| wave_out | output | 1 | Generated waveform |

## Verification
The period-end wrap and a setting update can land in the same cycle. This happens when the bench rewrites the duty compare while a PWM period is in progress, so the new value waits in the input while the wrap tick copies it into the shadow register. The bench synchronises on a rising output edge, changes the duty value, and then measures two things. The remainder of the current high phase must match the old duty. The next full period must match the new duty, with its period length unchanged. In the same way, an `enable` drop in the middle of a high phase is judged by requiring the output to be low at the next sample.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic {
    SHAPE_SQUARE = 1'b0,
    SHAPE_PULSE  = 1'b1
  } shape_e;
endpackage

// File: rtl/ptg_prescaler.sv
module ptg_prescaler #(
  parameter int PRESC_W = 16,
  parameter int SEL_W   = $clog2(PRESC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRESC_W-1:0] div_q;

  function automatic logic [PRESC_W-1:0] low_mask(input logic [SEL_W-1:0] n);
    logic [PRESC_W:0] one_hot;
    one_hot  = (PRESC_W+1)'(1) << n;
    low_mask = PRESC_W'(one_hot - 1'b1);
  endfunction

  assign tick = run && ((div_q & low_mask(sel)) == low_mask(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
    else          div_q <= '0;
  end
endmodule

// File: rtl/ptg_shadow.sv
module ptg_shadow #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic             pwm_in,
  input  logic             shape_in,
  input  logic [CNT_W-1:0] count_in,
  input  logic [CNT_W-1:0] reload_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic             pwm_act,
  output logic             shape_act,
  output logic [CNT_W-1:0] count_act,
  output logic [CNT_W-1:0] reload_act,
  output logic [CNT_W-1:0] duty_act,
  output logic             pwm_nxt,
  output logic             shape_nxt,
  output logic [CNT_W-1:0] duty_nxt
);
  logic load;
  assign load      = !run || wrap;
  assign pwm_nxt   = load ? pwm_in   : pwm_act;
  assign shape_nxt = load ? shape_in : shape_act;
  assign duty_nxt  = load ? duty_in  : duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_act    <= 1'b0;
      shape_act  <= 1'b0;
      count_act  <= '0;
      reload_act <= '0;
      duty_act   <= '0;
    end else if (load) begin
      pwm_act    <= pwm_in;
      shape_act  <= shape_in;
      count_act  <= count_in;
      reload_act <= reload_in;
      duty_act   <= duty_in;
    end
  end
endmodule

// File: rtl/ptg_counter.sv
module ptg_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrap
);
  // limit 0 wraps after 2^CNT_W ticks through modular subtraction
  function automatic logic at_end(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] lim);
    logic [CNT_W-1:0] last;
    last   = lim - 1'b1;
    at_end = (c == last);
  endfunction

  assign wrap     = tick && at_end(cnt_q, limit);
  assign cnt_next = wrap ? '0 : (tick ? cnt_q + 1'b1 : cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else           cnt_q <= cnt_next;
  end
endmodule

// File: rtl/ptg_shaper.sv
module ptg_shaper
  import ptg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap,
  input  logic             pwm_nxt,
  input  logic             shape_nxt,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] duty_nxt,
  output logic             wave_q
);
  function automatic logic pwm_level(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] d);
    pwm_level = (c < d);
  endfunction

  shape_e shape;
  assign shape = shape_e'(shape_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wave_q <= 1'b0;
    else if (!run)     wave_q <= 1'b0;
    else if (tick) begin
      if (pwm_nxt)                    wave_q <= pwm_level(cnt_next, duty_nxt);
      else if (shape == SHAPE_PULSE)  wave_q <= wrap;
      else if (wrap)                  wave_q <= ~wave_q;
    end
  end
endmodule

// File: rtl/pwm_timer_gen.sv
module pwm_timer_gen #(
  parameter int PRESC_W = 16,
  parameter int CNT_W   = 8,
  localparam int SEL_W  = $clog2(PRESC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             pwm_mode,
  input  logic             out_shape,
  input  logic [CNT_W-1:0] count_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] duty_val,
  output logic             wave_out
);
  logic             tick, wrap;
  logic             pwm_act, shape_act, pwm_nxt, shape_nxt;
  logic [CNT_W-1:0] count_act, reload_act, duty_act, duty_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_next, limit;

  ptg_prescaler #(.PRESC_W(PRESC_W), .SEL_W(SEL_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .run(enable), .sel(presc_sel), .tick(tick)
  );

  ptg_shadow #(.CNT_W(CNT_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .run(enable), .wrap(wrap),
    .pwm_in(pwm_mode), .shape_in(out_shape), .count_in(count_val),
    .reload_in(reload_val), .duty_in(duty_val),
    .pwm_act(pwm_act), .shape_act(shape_act), .count_act(count_act),
    .reload_act(reload_act), .duty_act(duty_act),
    .pwm_nxt(pwm_nxt), .shape_nxt(shape_nxt), .duty_nxt(duty_nxt)
  );

  assign limit = pwm_act ? reload_act : count_act;

  ptg_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick), .limit(limit),
    .cnt_q(cnt_q), .cnt_next(cnt_next), .wrap(wrap)
  );

  ptg_shaper #(.CNT_W(CNT_W)) shaper_i (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick), .wrap(wrap),
    .pwm_nxt(pwm_nxt), .shape_nxt(shape_nxt), .cnt_next(cnt_next),
    .duty_nxt(duty_nxt), .wave_q(wave_out)
  );
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [SEL_W-1:0] presc_sel,
  input logic             tick,
  input logic             wrap,
  input logic             pwm_act,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_act,
  input logic [CNT_W-1:0] duty_act,
  input logic             wave_out
);
  assert_tick_every_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && presc_sel == '0) |-> tick);

  assert_count_below_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pwm_act && reload_act != '0) |-> (cnt_q < reload_act));

  assert_settings_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wrap) |=> ($stable(duty_act) && $stable(reload_act)));

  assert_change_only_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(wave_out));

  assert_idle_output_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !wave_out);
endmodule

bind pwm_timer_gen ptg_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
  .tick(tick), .wrap(wrap), .pwm_act(pwm_act), .cnt_q(cnt_q),
  .reload_act(reload_act), .duty_act(duty_act), .wave_out(wave_out)
);

// File: tb/pwm_timer_gen_tb_top.sv
module pwm_timer_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] presc_sel = '0;
  logic       pwm_mode = 1'b0;
  logic       out_shape = 1'b0;
  logic [7:0] count_val = 8'd1;
  logic [7:0] reload_val = 8'd1;
  logic [7:0] duty_val = '0;
  logic       wave_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pwm_timer_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
    .pwm_mode(pwm_mode), .out_shape(out_shape), .count_val(count_val),
    .reload_val(reload_val), .duty_val(duty_val), .wave_out(wave_out)
  );

  typedef struct packed {
    logic [3:0] sel;
    logic       pwm;
    logic       shp;
    logic [7:0] lim;
    logic [7:0] duty;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 1'b0, 8'd3,  8'd0},
    '{4'd2,  1'b0, 1'b0, 8'd5,  8'd0},
    '{4'd0,  1'b0, 1'b0, 8'd0,  8'd0},
    '{4'd12, 1'b0, 1'b0, 8'd1,  8'd0},
    '{4'd1,  1'b0, 1'b1, 8'd4,  8'd0},
    '{4'd0,  1'b0, 1'b1, 8'd7,  8'd0},
    '{4'd0,  1'b1, 1'b0, 8'd10, 8'd3},
    '{4'd3,  1'b1, 1'b0, 8'd6,  8'd5},
    '{4'd1,  1'b1, 1'b0, 8'd0,  8'd128}
  };

  // expected high time and period, from the requirements
  function automatic void expect_of(input vec_t v, output int hi, output int per);
    int p, l;
    p = 1 << v.sel;
    l = (v.lim == 0) ? 256 : int'(v.lim);
    if (v.pwm)      begin per = l * p;     hi = int'(v.duty) * p; end
    else if (v.shp) begin per = l * p;     hi = p;                end
    else            begin per = 2 * l * p; hi = l * p;            end
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // measure one high phase and the following low phase, starting at a rising edge
  task automatic measure(input int tmo, output int hi, output int per);
    int n = 0;
    hi = -1; per = -1;
    while (wave_out && n < tmo)  begin @(negedge clk); n++; end
    while (!wave_out && n < tmo) begin @(negedge clk); n++; end
    if (n >= tmo) return;
    hi = 0;
    while (wave_out && n < tmo)  begin hi++; @(negedge clk); n++; end
    per = hi;
    while (!wave_out && n < tmo) begin per++; @(negedge clk); n++; end
    if (n >= tmo) begin hi = -1; per = -1; end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    presc_sel = v.sel; pwm_mode = v.pwm; out_shape = v.shp;
    count_val = v.lim; reload_val = v.lim; duty_val = v.duty;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic count_high(input int win, output int hi);
    hi = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (wave_out) hi++;
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int hi, per, ehi, eper;
    string tag;
    repeat (3) @(negedge clk);
    check("R9 output low in reset", int'(wave_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 output low after reset", int'(wave_out), 0);

    // table of settings, each checked for high time and period
    for (int k = 0; k < NV; k++) begin
      expect_of(VECS[k], ehi, eper);
      tag = VECS[k].pwm ? "R4" : (VECS[k].shp ? "R3" : "R2");
      if (VECS[k].sel != 0) tag = {"R1 ", tag};
      apply(VECS[k]);
      measure(4 * eper + 64, hi, per);
      measure(4 * eper + 64, hi, per);
      check({tag, " high time"}, hi, ehi);
      check({tag, " period"}, per, eper);
    end

    // constant outputs in PWM mode
    apply('{4'd0, 1'b1, 1'b0, 8'd5, 8'd0});
    repeat (20) @(negedge clk);
    count_high(40, hi);
    check("R5 duty zero stays low", hi, 0);
    apply('{4'd1, 1'b1, 1'b0, 8'd5, 8'd9});
    repeat (20) @(negedge clk);
    count_high(40, hi);
    check("R6 duty above reload stays high", hi, 40);
    apply('{4'd0, 1'b1, 1'b0, 8'd5, 8'd5});
    repeat (20) @(negedge clk);
    count_high(40, hi);
    check("R6 duty equal reload stays high", hi, 40);

    // mid-period duty change: old duty finishes, new one follows
    apply('{4'd0, 1'b1, 1'b0, 8'd8, 8'd2});
    measure(100, hi, per);
    measure(100, hi, per);
    measure(100, hi, per);
    // now sampling the first high cycle of a period
    duty_val = 8'd6;
    hi = 1;
    @(negedge clk);
    while (wave_out && hi < 50) begin hi++; @(negedge clk); end
    check("R7 current period keeps old duty", hi, 2);
    measure(100, hi, per);
    check("R7 next period takes new duty", hi, 6);
    check("R7 period unchanged", per, 8);

    // disable in the middle of a high phase
    apply('{4'd2, 1'b0, 1'b0, 8'd4, 8'd0});
    measure(200, hi, per);
    while (!wave_out) @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R8 output low after disable", int'(wave_out), 0);
    count_high(30, hi);
    check("R8 output stays low while disabled", hi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule